// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

This block runs once after reset and builds a one-bit-per-block table of the erase blocks that left the factory defective. It walks the blocks of one die in ascending order. For each block it asks a lower-level flash controller for a single data word: the first spare-area location of page 0. The request carries the block number and the column. The controller answers with the word and an error flag. A word equal to the defect mark (all zeros at the bus width) marks the block bad. A read that comes back with an error also marks the block bad. Any other value leaves the block good.

Block 0 is guaranteed good, so it is never read and is always recorded as good. The block counts the bad blocks as it goes. It raises a sticky flag when the die drops below its guaranteed number of valid blocks, and it still scans to the end.

Other logic reads the table through a registered lookup port. The block also gates the path for program and erase requests, and lets them through only once the table is complete.

Top module: `nand_bb_scan`

## Requirements
- R1: After reset the block issues read requests for blocks 1, 2, … NUM_BLOCKS-1 in ascending order, one at a time. Each request is held with an unchanged block number until `rd_req_ready` accepts it. The column is 2048 when BUS_W is 8 and 1024 when BUS_W is 16.
- R2: Block 0 is never requested, and its table bit always reads 0 (good).
- R3: A table bit of 1 means bad. A block is recorded bad when its response has `rd_rsp_err`=1, or when its data is all zeros. Any other data, including all ones, records it good.
- R4: A response that arrives while no request is outstanding is ignored. It changes neither the table nor the count.
- R5: `lk_bad` returns the table bit of `lk_block` one cycle after `lk_block` is presented. If that block is written in the same cycle, `lk_bad` shows the old bit first and the new bit one cycle later.
- R6: `scan_done` is high for exactly one cycle, the cycle after the last block's response is taken. `table_valid` is low in that cycle, goes high in the next cycle, and stays high until reset.
- R7: `bad_count` reads 0 until `scan_done` is asserted. From then on it holds the number of bad blocks as a 13-bit value.
- R8: `nvb_violation` goes high in the cycle after the number of bad blocks first exceeds NUM_BLOCKS-MIN_VALID (80 by default). It stays high until reset, and the scan continues to the last block.
- R9: `pe_out_valid` equals `pe_in_valid` and `pe_in_ready` equals `pe_out_ready` while `table_valid` is high. Both are held at 0 while it is low.
- R10: While reset is active, `rd_req_valid`, `scan_done`, `table_valid`, `nvb_violation` and `bad_count` are 0, and every table bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the scan when released |
| rd_req_valid | output | 1 | Read request to the flash controller |
| rd_req_ready | input | 1 | Controller accepts the request |
| rd_req_block | output | 12 | Block number to read (page 0) |
| rd_req_col | output | 12 | Column of the first spare-area location |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | BUS_W (8) | Word read from the spare location |
| rd_rsp_err | input | 1 | Read response carries an error |
| lk_block | input | 12 | Block number to look up |
| lk_bad | output | 1 | Table bit of the looked-up block, one cycle later |
| scan_done | output | 1 | One-cycle pulse when the scan completes |
| table_valid | output | 1 | Table complete; level signal |
| bad_count | output | 13 | Number of bad blocks, shown from `scan_done` on |
| nvb_violation | output | 1 | Sticky: more bad blocks than the die allows |
| pe_in_valid | input | 1 | Upstream program/erase request |
| pe_in_ready | output | 1 | Ready returned upstream, gated by `table_valid` |
| pe_out_valid | output | 1 | Program/erase request passed on, gated by `table_valid` |
| pe_out_ready | input | 1 | Downstream ready |

## Verification
A table lookup and a table write can fall in the same cycle. This happens when a lookup targets the block whose response is being taken. The bench provokes this by setting `lk_block` to a bad block just before its response edge. It expects the old good bit on the first sample and the bad bit one cycle later.

The threshold crossing and the end of the scan can also meet. The bench places the 81st bad block at a known position, checks that the flag rises while `table_valid` is still low, and checks a run with exactly 80 bad blocks that leaves the flag low.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_ISSUE,
        SC_WAIT,
        SC_FIN,
        SC_DONE
    } scan_state_e;

    typedef struct packed {
        logic wr;
        logic bad;
    } verdict_t;

    // Column of the first spare word: the data area size in bus words.
    function automatic int spare_col(input int bus_w, input int page_bytes);
        return page_bytes / (bus_w / 8);
    endfunction

endpackage

// File: rtl/nbs_seq.sv
module nbs_seq
    import nbs_pkg::*;
#(
    parameter int NUM_BLOCKS = 4096,
    parameter int BLK_W      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_ready,
    input  logic             rsp_valid,
    output logic             req_valid,
    output logic [BLK_W-1:0] cur_blk,
    output logic             accept,
    output scan_state_e      state
);
    localparam logic [BLK_W-1:0] LAST_BLK  = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [BLK_W-1:0] FIRST_BLK = BLK_W'(1);

    scan_state_e state_q;

    assign state     = state_q;
    assign req_valid = (state_q == SC_ISSUE);
    assign accept    = (state_q == SC_WAIT) && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_IDLE;
            cur_blk <= FIRST_BLK;
        end else begin
            unique case (state_q)
                SC_IDLE:  state_q <= SC_ISSUE;
                SC_ISSUE: if (req_ready) state_q <= SC_WAIT;
                SC_WAIT: begin
                    if (rsp_valid) begin
                        if (cur_blk == LAST_BLK) begin
                            state_q <= SC_FIN;
                        end else begin
                            cur_blk <= cur_blk + BLK_W'(1);
                            state_q <= SC_ISSUE;
                        end
                    end
                end
                SC_FIN:   state_q <= SC_DONE;
                SC_DONE:  state_q <= SC_DONE;
                default:  state_q <= SC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nbs_judge.sv
module nbs_judge
    import nbs_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             accept,
    input  logic [BUS_W-1:0] data,
    input  logic             err,
    output verdict_t         verdict
);
    logic is_mark;

    generate
        if (BUS_W == 16) begin : g_wide
            assign is_mark = (data[15:8] == 8'h00) && (data[7:0] == 8'h00);
        end else begin : g_narrow
            assign is_mark = (data == '0);
        end
    endgenerate

    always_comb begin
        verdict.wr  = accept;
        verdict.bad = err | is_mark;
    end
endmodule

// File: rtl/nbs_table.sv
module nbs_table
    import nbs_pkg::*;
#(
    parameter int NUM_BLOCKS = 4096,
    parameter int BLK_W      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  verdict_t         verdict,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic [BLK_W-1:0] lk_block,
    output logic             lk_bad
);
    logic [NUM_BLOCKS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            lk_bad <= 1'b0;
        end else begin
            // Read uses the pre-edge contents: a same-cycle write shows next cycle.
            lk_bad <= bits_q[lk_block];
            if (verdict.wr && (wr_blk != '0)) begin
                bits_q[wr_blk] <= verdict.bad;
            end
        end
    end
endmodule

// File: rtl/nbs_tally.sv
module nbs_tally #(
    parameter int CNT_W = 13,
    parameter int LIMIT = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             over
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] next_cnt;
    assign next_cnt = count + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            over  <= 1'b0;
        end else if (inc) begin
            count <= next_cnt;
            if (next_cnt > LIM) over <= 1'b1;
        end
    end
endmodule

// File: rtl/nand_bb_scan.sv
module nand_bb_scan
    import nbs_pkg::*;
#(
    parameter int NUM_BLOCKS = 4096,
    parameter int MIN_VALID  = 4016,
    parameter int BUS_W      = 8,
    parameter int PAGE_BYTES = 2048,
    parameter int COL_W      = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic                          rd_req_valid,
    input  logic                          rd_req_ready,
    output logic [$clog2(NUM_BLOCKS)-1:0] rd_req_block,
    output logic [COL_W-1:0]              rd_req_col,
    input  logic                          rd_rsp_valid,
    input  logic [BUS_W-1:0]              rd_rsp_data,
    input  logic                          rd_rsp_err,
    input  logic [$clog2(NUM_BLOCKS)-1:0] lk_block,
    output logic                          lk_bad,
    output logic                          scan_done,
    output logic                          table_valid,
    output logic [$clog2(NUM_BLOCKS):0]   bad_count,
    output logic                          nvb_violation,
    input  logic                          pe_in_valid,
    output logic                          pe_in_ready,
    output logic                          pe_out_valid,
    input  logic                          pe_out_ready
);
    localparam int BLK_W     = $clog2(NUM_BLOCKS);
    localparam int CNT_W     = BLK_W + 1;
    localparam int BAD_LIMIT = NUM_BLOCKS - MIN_VALID;
    localparam int SPARE_COL = spare_col(BUS_W, PAGE_BYTES);

    scan_state_e      state;
    logic [BLK_W-1:0] cur_blk;
    logic             accept;
    verdict_t         verdict;
    logic [CNT_W-1:0] count;

    nbs_seq #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_ready (rd_req_ready),
        .rsp_valid (rd_rsp_valid),
        .req_valid (rd_req_valid),
        .cur_blk   (cur_blk),
        .accept    (accept),
        .state     (state)
    );

    nbs_judge #(.BUS_W(BUS_W)) u_judge (
        .accept  (accept),
        .data    (rd_rsp_data),
        .err     (rd_rsp_err),
        .verdict (verdict)
    );

    nbs_table #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .wr_blk   (cur_blk),
        .lk_block (lk_block),
        .lk_bad   (lk_bad)
    );

    nbs_tally #(.CNT_W(CNT_W), .LIMIT(BAD_LIMIT)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .inc   (verdict.wr & verdict.bad),
        .count (count),
        .over  (nvb_violation)
    );

    assign rd_req_block = cur_blk;
    assign rd_req_col   = COL_W'(SPARE_COL);
    assign scan_done    = (state == SC_FIN);
    assign table_valid  = (state == SC_DONE);
    assign bad_count    = (scan_done || table_valid) ? count : '0;
    assign pe_out_valid = pe_in_valid & table_valid;
    assign pe_in_ready  = pe_out_ready & table_valid;
endmodule

// File: rtl/nand_bb_scan_chk.sv
module nand_bb_scan_chk #(
    parameter int BLK_W = 12,
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [BLK_W-1:0] rd_req_block,
    input logic             scan_done,
    input logic             table_valid,
    input logic [CNT_W-1:0] bad_count,
    input logic             nvb_violation,
    input logic             pe_in_valid,
    input logic             pe_out_valid,
    input logic             pe_in_ready
);
    a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_block)));

    a_r2_no_block0: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (rd_req_block != '0));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> (!scan_done && table_valid));

    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        table_valid |=> table_valid);

    a_r6_no_req_after: assert property (@(posedge clk) disable iff (rst)
        table_valid |-> !rd_req_valid);

    a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
        table_valid |=> $stable(bad_count));

    a_r8_nvb_sticky: assert property (@(posedge clk) disable iff (rst)
        nvb_violation |=> nvb_violation);

    a_r9_gate_closed: assert property (@(posedge clk) disable iff (rst)
        !table_valid |-> (!pe_out_valid && !pe_in_ready));

    a_r9_gate_open: assert property (@(posedge clk) disable iff (rst)
        (table_valid && pe_in_valid) |-> pe_out_valid);
endmodule

bind nand_bb_scan nand_bb_scan_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_req_block  (rd_req_block),
    .scan_done     (scan_done),
    .table_valid   (table_valid),
    .bad_count     (bad_count),
    .nvb_violation (nvb_violation),
    .pe_in_valid   (pe_in_valid),
    .pe_out_valid  (pe_out_valid),
    .pe_in_ready   (pe_in_ready)
);

// File: tb/nand_bb_scan_bench.sv
`timescale 1ns/1ps
module nand_bb_scan_bench;
    localparam int NB      = 4096;
    localparam int LIMIT   = 80;
    localparam int EXP_COL = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [11:0] rd_req_block;
    logic [11:0] rd_req_col;
    logic        rd_rsp_valid = 1'b0;
    logic [7:0]  rd_rsp_data = 8'h00;
    logic        rd_rsp_err = 1'b0;
    logic [11:0] lk_block = '0;
    logic        lk_bad;
    logic        scan_done;
    logic        table_valid;
    logic [12:0] bad_count;
    logic        nvb_violation;
    logic        pe_in_valid = 1'b0;
    logic        pe_in_ready;
    logic        pe_out_valid;
    logic        pe_out_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int order_err = 0;
    bit exp_bad [NB];

    always #2.5 clk = ~clk;

    nand_bb_scan u_nand_bb_scan (
        .clk(clk), .rst(rst),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_block(rd_req_block), .rd_req_col(rd_req_col),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .lk_block(lk_block), .lk_bad(lk_bad),
        .scan_done(scan_done), .table_valid(table_valid),
        .bad_count(bad_count), .nvb_violation(nvb_violation),
        .pe_in_valid(pe_in_valid), .pe_in_ready(pe_in_ready),
        .pe_out_valid(pe_out_valid), .pe_out_ready(pe_out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int count_bad();
        int n = 0;
        for (int b = 0; b < NB; b++) n += exp_bad[b];
        return n;
    endfunction

    function automatic void build_pattern(input int kind);
        for (int b = 0; b < NB; b++) begin
            case (kind)
                0:       exp_bad[b] = ($urandom % 100) == 0;
                1:       exp_bad[b] = (b % 50 == 1) && (b <= 4001);
                default: exp_bad[b] = (b % 50 == 1) && (b <= 3951);
            endcase
        end
        exp_bad[0] = 1'b0;
        if (kind == 0) begin
            exp_bad[1]    = 1'b1;
            exp_bad[10]   = 1'b0;
            exp_bad[NB-1] = 1'b1;
        end
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_err = 0; rd_rsp_data = 0;
        pe_in_valid = 0; pe_out_ready = 0; lk_block = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!rd_req_valid && !scan_done && !table_valid, "R10 ctrl idle",
            {rd_req_valid, scan_done, table_valid}, 0);
        chk(bad_count == 0 && !nvb_violation, "R10 count/flag clear",
            int'(bad_count) + int'(nvb_violation), 0);
        rst = 1'b0;
    endtask

    task automatic serve(input int blk, input bit probe, input bit stray);
        int n = 0;
        logic [7:0] d;
        while (!rd_req_valid && n < 50) begin @(negedge clk); n++; end
        // R1 / R2: order, block and column
        if (!rd_req_valid || rd_req_block !== 12'(blk) || rd_req_col !== 12'(EXP_COL)) order_err++;
        if (stray) begin
            // R4: a response with no request outstanding
            rd_rsp_valid = 1; rd_rsp_data = 8'h00; rd_rsp_err = 1;
            @(negedge clk);
            rd_rsp_valid = 0; rd_rsp_err = 0;
            if (!rd_req_valid || rd_req_block !== 12'(blk)) order_err++;
        end
        if ($urandom % 4 == 0) begin
            @(negedge clk);
            if (!rd_req_valid || rd_req_block !== 12'(blk)) order_err++;
        end
        rd_req_ready = 1;
        @(negedge clk);
        rd_req_ready = 0;
        if (rd_req_valid) order_err++;
        repeat ($urandom % 3) @(negedge clk);
        if (probe) lk_block = 12'(blk);
        if (exp_bad[blk]) begin
            if ($urandom % 2 == 0) begin
                rd_rsp_err = 1; rd_rsp_data = 8'h5A;
            end else begin
                rd_rsp_err = 0; rd_rsp_data = 8'h00;
            end
        end else begin
            d = 8'($urandom);
            if (d == 8'h00) d = 8'hFF;
            rd_rsp_err = 0; rd_rsp_data = d;
        end
        rd_rsp_valid = 1;
        @(negedge clk);
        rd_rsp_valid = 0; rd_rsp_err = 0;
        if (probe) begin
            // R5: same-cycle write shows old bit, then new bit
            chk(lk_bad == 1'b0, "R5 lookup old value", lk_bad, 0);
            @(negedge clk);
            chk(lk_bad == exp_bad[blk], "R5 lookup new value", lk_bad, exp_bad[blk]);
        end
    endtask

    task automatic run_scan(input int kind);
        int exp_n;
        int mism;
        int first_bad_blk;
        build_pattern(kind);
        exp_n = count_bad();
        order_err = 0;
        do_reset();
        for (int b = 1; b < NB; b++) begin
            if (b == 2000) begin
                // R7: count hidden mid-scan; R9: gate closed
                chk(bad_count == 0 && !table_valid, "R7 count hidden mid-scan", bad_count, 0);
                pe_in_valid = 1; pe_out_ready = 1;
                #1;
                chk(!pe_out_valid && !pe_in_ready, "R9 gate closed during scan",
                    {pe_out_valid, pe_in_ready}, 0);
                pe_in_valid = 0; pe_out_ready = 0;
            end
            serve(b, (kind == 0 && b == 1), (kind == 0 && b == 10));
            if (kind == 1 && b == 4001) begin
                // R8: flag rises before the scan ends
                chk(nvb_violation && !table_valid, "R8 flag raised mid-scan",
                    {nvb_violation, table_valid}, 2);
            end
        end
        // R6 / R7 / R8 at completion
        chk(scan_done && !table_valid, "R6 done pulse, valid low", {scan_done, table_valid}, 2);
        chk(bad_count == 13'(exp_n), "R7 bad count", bad_count, exp_n);
        chk(nvb_violation == (exp_n > LIMIT), "R8 violation flag", nvb_violation, exp_n > LIMIT);
        @(negedge clk);
        chk(!scan_done && table_valid, "R6 valid level after pulse", {scan_done, table_valid}, 1);
        chk(order_err == 0, "R1 request order/column/hold", order_err, 0);
        // R3 / R2: sweep the whole table
        mism = 0; first_bad_blk = -1;
        for (int b = 0; b < NB; b++) begin
            lk_block = 12'(b);
            @(negedge clk);
            if (lk_bad !== exp_bad[b]) begin
                mism++;
                if (first_bad_blk < 0) first_bad_blk = b;
            end
        end
        chk(mism == 0, "R3 table contents (mismatches)", mism, 0);
        lk_block = 12'd0;
        @(negedge clk);
        chk(lk_bad == 1'b0, "R2 block 0 good", lk_bad, 0);
        if (kind == 0) begin
            lk_block = 12'd10;
            @(negedge clk);
            chk(lk_bad == 1'b0, "R4 stray response ignored", lk_bad, 0);
        end
        // R9: gate open
        pe_in_valid = 1; pe_out_ready = 0;
        #1;
        chk(pe_out_valid && !pe_in_ready, "R9 valid passes", {pe_out_valid, pe_in_ready}, 2);
        pe_in_valid = 0; pe_out_ready = 1;
        #1;
        chk(!pe_out_valid && pe_in_ready, "R9 ready passes", {pe_out_valid, pe_in_ready}, 1);
        pe_out_ready = 0;
        repeat (5) @(negedge clk);
        chk(table_valid && bad_count == 13'(exp_n) && nvb_violation == (exp_n > LIMIT),
            "R8 status held after scan", bad_count, exp_n);
    endtask

    initial begin
        void'($urandom(32'd4711));
        run_scan(0);
        run_scan(1);
        run_scan(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule